// File: doc/BRIEF.md
# Async HDLC Receive Deframer

This block sits behind an 8N1 UART receiver. It turns the stream of received octets back into frames. Flag octets (0x7E) mark frame edges. They are consumed and never appear as data. One flag may close one frame and open the next, and a run of flags between frames produces nothing. Escape octets (0x7D) are removed, and the octet that follows is exclusive-ORed with 0x20. Control characters that the receive map marks as line noise are dropped. The frame check sequence is verified over the unescaped octets.

Every surviving frame octet is handed to the consumer on a one-cycle output strobe, and the first octet of a frame is marked. The two FCS octets are delivered as the last two data octets. Each frame then ends with a separate end beat that carries the status:

- a CRC error;
- a short frame;
- an abort;
- a line error.

An abort is an escape followed directly by a flag. A line error is a framing error, overrun, break or loss of carrier. Both make the block drop back to hunting for a flag. Address and control octets are not interpreted; they pass through as ordinary data.

Top module: `ahdlc_rx_deframer`

## Requirements
- R1: After reset, `out_valid`, `out_eof` and all status outputs are 0. The block hunts for a flag, and octets received before the first 0x7E produce no output.
- R2: Each non-flag octet received inside a frame appears on `out_byte` with `out_valid` high, in arrival order, on the clock edge that accepts it. `out_sof` is high only with the first octet of each frame. A 0x7E octet received unescaped is never delivered. `out_valid` and `out_eof` are never high together.
- R3: A 0x7E after one or more frame octets closes the frame and opens the next one. A 0x7E with no frame octets since the previous flag produces no output.
- R4: An octet presented with `in_idle` high is ignored completely. This holds even when the octet is 0x7E or 0x7D.
- R5: An unescaped 0x7D is removed, and the next accepted non-flag octet is delivered XORed with 0x20. This applies to unmapped control characters (0x7D 0x01 gives 0x21) and to a second 0x7D (0x7D 0x7D gives 0x5D).
- R6: A received octet below 0x20 whose bit in `rx_map` is 1 (bit n for value n) is dropped, and a pending escape stays pending across it. Control octets whose map bit is 0 are delivered.
- R7: At the closing flag, `out_crc_err` is 0 when the CRC register equals 0xF0B8, and 1 otherwise. The register starts at 0xFFFF at each flag and is updated with the reflected polynomial 0x8408 over every delivered octet, FCS included.
- R8: At the closing flag, `out_short` is 1 when fewer than 4 octets (FCS included) were delivered, and 0 for 4 or more.
- R9: 0x7D followed by 0x7E inside a frame produces an end beat with `out_abort`=1 and `out_crc_err`=`out_short`=0. The block then hunts, so octets are discarded until the next 0x7E.
- R10: A framing error, overrun, break or carrier loss during a frame that has delivered octets or holds a pending escape produces an end beat with `out_line_err`=1 and no other status. The block then hunts. The same error between frames produces no end beat.
- R11: Address and control octets such as 0xFF 0x03 are delivered unchanged, with no check or substitution.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A received octet is present on `in_byte` |
| in_idle | input | 1 | The present octet is an idle character and must be ignored |
| in_byte | input | 8 | Received octet from the UART |
| err_framing | input | 1 | UART framing-error pulse |
| err_overrun | input | 1 | UART overrun pulse |
| err_break | input | 1 | Break-detected pulse |
| carrier_lost | input | 1 | Carrier-loss pulse |
| rx_map | input | 32 | Receive control-character map, bit n drops octet value n |
| out_valid | output | 1 | Frame octet strobe |
| out_byte | output | 8 | Frame octet, unescaped |
| out_sof | output | 1 | First octet of a frame |
| out_eof | output | 1 | End-of-frame beat; status outputs are valid |
| out_crc_err | output | 1 | FCS residual mismatch |
| out_short | output | 1 | Fewer than 4 octets in the frame |
| out_abort | output | 1 | Frame ended by escape-then-flag |
| out_line_err | output | 1 | Frame ended by a UART line error |

## Verification
The hardest case to reach is a mapped control character arriving between an escape and the octet it modifies. The escape must survive the dropped octet. Reaching this takes a hand-built raw stream (0x7D 0x11 0x5E with bit 17 of the map set) rather than the bench's normal encoder. The bench also drives raw 0x7D 0x7D and 0x7D 0x01 sequences that no sane transmitter emits. It computes the FCS over the octets the receiver should deliver, so a wrong unescape rule shows up both in the data and in the CRC status. Each line-error type is injected both mid-frame and right after a flag, to separate the reported case from the silent one.

// File: rtl/ahdlc_pkg.sv
package ahdlc_pkg;

    localparam logic [7:0]  FLAG_OCTET = 8'h7E;
    localparam logic [7:0]  ESC_OCTET  = 8'h7D;
    localparam logic [7:0]  ESC_FLIP   = 8'h20;
    localparam logic [15:0] CRC_SEED   = 16'hFFFF;
    localparam logic [15:0] CRC_MAGIC  = 16'hF0B8;
    localparam logic [15:0] CRC_POLY_R = 16'h8408;

    typedef enum logic [1:0] {
        TK_NONE,
        TK_DATA,
        TK_FLAG,
        TK_ABORT
    } tok_kind_e;

    typedef struct packed {
        tok_kind_e  kind;
        logic [7:0] octet;
    } tok_t;

    typedef struct packed {
        logic crc_bad;
        logic too_short;
        logic aborted;
        logic line_fault;
    } fstat_t;

    typedef enum logic {
        FS_HUNT,
        FS_OPEN
    } frame_state_e;

    function automatic logic [15:0] crc_step(input logic [15:0] cur, input logic [7:0] oct);
        logic [15:0] r;
        r = cur ^ {8'h00, oct};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/ahdlc_unescape.sv
module ahdlc_unescape
    import ahdlc_pkg::*;
#(
    parameter int MAP_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic [7:0]       acc_octet,
    input  logic [MAP_W-1:0] noise_map,
    input  logic             flush,
    output tok_t             tok,
    output logic             esc_pending
);
    localparam int         IDX_W   = $clog2(MAP_W);
    localparam logic [8:0] MAP_LIM = 9'(MAP_W);

    logic esc_q, esc_d;
    logic is_ctrl, is_noise;

    assign is_ctrl  = ({1'b0, acc_octet} < MAP_LIM);
    assign is_noise = is_ctrl && noise_map[acc_octet[IDX_W-1:0]];

    always_comb begin
        tok.kind  = TK_NONE;
        tok.octet = acc_octet;
        esc_d     = esc_q;
        if (flush) begin
            esc_d = 1'b0;
        end else if (acc_valid) begin
            if (acc_octet == FLAG_OCTET) begin
                tok.kind = esc_q ? TK_ABORT : TK_FLAG;
                esc_d    = 1'b0;
            end else if (is_noise) begin
                tok.kind = TK_NONE;
            end else if (esc_q) begin
                tok.kind  = TK_DATA;
                tok.octet = acc_octet ^ ESC_FLIP;
                esc_d     = 1'b0;
            end else if (acc_octet == ESC_OCTET) begin
                esc_d = 1'b1;
            end else begin
                tok.kind = TK_DATA;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) esc_q <= 1'b0;
        else     esc_q <= esc_d;
    end

    assign esc_pending = esc_q;

endmodule

// File: rtl/ahdlc_crc16.sv
module ahdlc_crc16
    import ahdlc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        advance,
    input  logic [7:0]  octet,
    output logic [15:0] crc
);
    logic [15:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clear) crc_q <= CRC_SEED;
        else if (advance) crc_q <= crc_step(crc_q, octet);
    end

    assign crc = crc_q;

endmodule

// File: rtl/ahdlc_frame_ctl.sv
module ahdlc_frame_ctl
    import ahdlc_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int MIN_LEN = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  tok_t        tok,
    input  logic        line_err,
    input  logic        esc_pending,
    input  logic [15:0] crc,
    output logic        crc_clear,
    output logic        crc_adv,
    output logic        o_valid,
    output logic [7:0]  o_octet,
    output logic        o_sof,
    output logic        o_eof,
    output fstat_t      o_stat
);
    localparam logic [CNT_W-1:0] LEN_MIN = CNT_W'(MIN_LEN);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    frame_state_e     st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             v_d, sof_d, eof_d;
    logic [7:0]       oct_d;
    fstat_t           stat_d;

    always_comb begin
        st_d      = st_q;
        cnt_d     = cnt_q;
        v_d       = 1'b0;
        sof_d     = 1'b0;
        eof_d     = 1'b0;
        oct_d     = tok.octet;
        stat_d    = '0;
        crc_clear = 1'b0;
        crc_adv   = 1'b0;
        if (line_err) begin
            if (st_q == FS_OPEN && (cnt_q != '0 || esc_pending)) begin
                eof_d             = 1'b1;
                stat_d.line_fault = 1'b1;
            end
            st_d  = FS_HUNT;
            cnt_d = '0;
        end else begin
            unique case (tok.kind)
                TK_FLAG: begin
                    if (st_q == FS_OPEN && cnt_q != '0) begin
                        eof_d            = 1'b1;
                        stat_d.crc_bad   = (crc != CRC_MAGIC);
                        stat_d.too_short = (cnt_q < LEN_MIN);
                    end
                    st_d      = FS_OPEN;
                    cnt_d     = '0;
                    crc_clear = 1'b1;
                end
                TK_ABORT: begin
                    if (st_q == FS_OPEN) begin
                        eof_d          = 1'b1;
                        stat_d.aborted = 1'b1;
                    end
                    st_d  = FS_HUNT;
                    cnt_d = '0;
                end
                TK_DATA: begin
                    if (st_q == FS_OPEN) begin
                        v_d     = 1'b1;
                        sof_d   = (cnt_q == '0);
                        crc_adv = 1'b1;
                        if (cnt_q != CNT_TOP) cnt_d = cnt_q + 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= FS_HUNT;
            cnt_q   <= '0;
            o_valid <= 1'b0;
            o_sof   <= 1'b0;
            o_eof   <= 1'b0;
            o_octet <= '0;
            o_stat  <= '0;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            o_valid <= v_d;
            o_sof   <= sof_d;
            o_eof   <= eof_d;
            o_octet <= v_d ? oct_d : 8'h00;
            o_stat  <= stat_d;
        end
    end

endmodule

// File: rtl/ahdlc_rx_deframer.sv
module ahdlc_rx_deframer
    import ahdlc_pkg::*;
#(
    parameter int MAP_W   = 32,
    parameter int CNT_W   = 16,
    parameter int MIN_LEN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_idle,
    input  logic [7:0]       in_byte,
    input  logic             err_framing,
    input  logic             err_overrun,
    input  logic             err_break,
    input  logic             carrier_lost,
    input  logic [MAP_W-1:0] rx_map,
    output logic             out_valid,
    output logic [7:0]       out_byte,
    output logic             out_sof,
    output logic             out_eof,
    output logic             out_crc_err,
    output logic             out_short,
    output logic             out_abort,
    output logic             out_line_err
);
    logic        acc_valid;
    logic        line_err;
    tok_t        tok;
    logic        esc_pending;
    logic        crc_clear, crc_adv;
    logic [15:0] crc;
    fstat_t      stat;

    assign acc_valid = in_valid && !in_idle;
    assign line_err  = err_framing || err_overrun || err_break || carrier_lost;

    ahdlc_unescape #(.MAP_W(MAP_W)) u_unesc (
        .clk         (clk),
        .rst         (rst),
        .acc_valid   (acc_valid),
        .acc_octet   (in_byte),
        .noise_map   (rx_map),
        .flush       (line_err),
        .tok         (tok),
        .esc_pending (esc_pending)
    );

    ahdlc_crc16 u_crc (
        .clk     (clk),
        .rst     (rst),
        .clear   (crc_clear),
        .advance (crc_adv),
        .octet   (tok.octet),
        .crc     (crc)
    );

    ahdlc_frame_ctl #(.CNT_W(CNT_W), .MIN_LEN(MIN_LEN)) u_ctl (
        .clk         (clk),
        .rst         (rst),
        .tok         (tok),
        .line_err    (line_err),
        .esc_pending (esc_pending),
        .crc         (crc),
        .crc_clear   (crc_clear),
        .crc_adv     (crc_adv),
        .o_valid     (out_valid),
        .o_octet     (out_byte),
        .o_sof       (out_sof),
        .o_eof       (out_eof),
        .o_stat      (stat)
    );

    assign out_crc_err  = stat.crc_bad;
    assign out_short    = stat.too_short;
    assign out_abort    = stat.aborted;
    assign out_line_err = stat.line_fault;

endmodule

// File: rtl/ahdlc_rx_chk.sv
module ahdlc_rx_chk #(
    parameter int MAP_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_idle,
    input logic [7:0]       in_byte,
    input logic             err_framing,
    input logic             err_overrun,
    input logic             err_break,
    input logic             carrier_lost,
    input logic [MAP_W-1:0] rx_map,
    input logic             out_valid,
    input logic             out_sof,
    input logic             out_eof,
    input logic             out_crc_err,
    input logic             out_short,
    input logic             out_abort,
    input logic             out_line_err
);
    localparam int         IDX_W   = $clog2(MAP_W);
    localparam logic [8:0] MAP_LIM = 9'(MAP_W);

    logic any_err;
    logic noise_in;
    assign any_err  = err_framing || err_overrun || err_break || carrier_lost;
    assign noise_in = ({1'b0, in_byte} < MAP_LIM) && rx_map[in_byte[IDX_W-1:0]];

    // R2
    valid_eof_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_eof));

    // R2
    sof_with_data_chk: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> out_valid);

    // R1
    status_only_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        !out_eof |-> !(out_crc_err || out_short || out_abort || out_line_err));

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_idle && !any_err) |=> (!out_valid && !out_eof));

    // R6
    noise_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_idle && noise_in && !any_err) |=> (!out_valid && !out_eof));

    // R10
    line_err_no_data_chk: assert property (@(posedge clk) disable iff (rst)
        any_err |=> !out_valid);

    // R10
    term_cause_only_chk: assert property (@(posedge clk) disable iff (rst)
        (out_eof && (out_abort || out_line_err)) |->
            (!out_crc_err && !out_short && !(out_abort && out_line_err)));

endmodule

bind ahdlc_rx_deframer ahdlc_rx_chk #(.MAP_W(MAP_W)) u_chk (.*);

// File: tb/sim_ahdlc_rx_deframer.sv
`timescale 1ns/1ps
module sim_ahdlc_rx_deframer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_idle = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        err_framing = 1'b0;
    logic        err_overrun = 1'b0;
    logic        err_break = 1'b0;
    logic        carrier_lost = 1'b0;
    logic [31:0] rx_map = 32'h0;
    logic        out_valid, out_sof, out_eof;
    logic [7:0]  out_byte;
    logic        out_crc_err, out_short, out_abort, out_line_err;

    always #2 clk = ~clk;

    ahdlc_rx_deframer u0 (.*);

    int nchk = 0;
    int nfail = 0;
    int ncap = 0;
    int neof = 0;
    logic [7:0] cap  [0:63];
    logic       csof [0:63];
    logic [3:0] est  [0:7];   // {crc, short, abort, line}
    logic [7:0] pay  [0:31];
    int plen = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid && ncap < 64) begin
                cap[ncap]  = out_byte;
                csof[ncap] = out_sof;
                ncap++;
            end
            if (out_eof) begin
                if (neof < 8) est[neof] = {out_crc_err, out_short, out_abort, out_line_err};
                neof++;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_fcs(input int n);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ {8'h00, pay[i]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic send_raw(input logic [7:0] b);
        in_valid = 1'b1; in_byte = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_idle(input logic [7:0] b);
        in_valid = 1'b1; in_idle = 1'b1; in_byte = b;
        @(negedge clk);
        in_valid = 1'b0; in_idle = 1'b0;
    endtask

    task automatic send_enc(input logic [7:0] b);
        if (b == 8'h7E || b == 8'h7D || b < 8'h20) begin
            send_raw(8'h7D);
            send_raw(b ^ 8'h20);
        end else begin
            send_raw(b);
        end
    endtask

    task automatic send_fcs(input logic flip);
        logic [15:0] f = ref_fcs(plen);
        send_enc(f[7:0] ^ {7'd0, flip});
        send_enc(f[15:8]);
    endtask

    task automatic send_payload_fcs();
        for (int i = 0; i < plen; i++) send_enc(pay[i]);
        send_fcs(1'b0);
    endtask

    task automatic pulse_err(input int k);
        case (k)
            0: err_framing = 1'b1;
            1: err_overrun = 1'b1;
            2: err_break = 1'b1;
            default: carrier_lost = 1'b1;
        endcase
        @(negedge clk);
        err_framing = 1'b0; err_overrun = 1'b0; err_break = 1'b0; carrier_lost = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_mon();
        ncap = 0; neof = 0;
    endtask

    task automatic check_delivered(input string req);
        logic [15:0] f = ref_fcs(plen);
        check({req, " count"}, ncap, plen + 2);
        for (int i = 0; i < plen; i++) check({req, " data"}, cap[i], pay[i]);
        check({req, " fcs lo"}, cap[plen], f[7:0]);
        check({req, " fcs hi"}, cap[plen+1], f[15:8]);
        check({req, " sof first"}, csof[0], 1);
        check({req, " sof second"}, csof[1], 0);
    endtask

    task automatic test_reset();
        check("R1 out_valid", out_valid, 0);
        check("R1 out_eof", out_eof, 0);
        check("R1 status", {out_crc_err, out_short, out_abort, out_line_err}, 0);
        clear_mon();
        send_raw(8'h11); send_raw(8'h22); send_raw(8'h33);
        settle();
        check("R1 pre-flag octets", ncap, 0);
        check("R1 pre-flag eof", neof, 0);
    endtask

    task automatic test_good_frame();
        clear_mon();
        pay[0] = 8'hFF; pay[1] = 8'h03; pay[2] = 8'hC0; pay[3] = 8'h21; pay[4] = 8'h01; plen = 5;
        send_raw(8'h7E); send_payload_fcs(); send_raw(8'h7E);
        settle();
        check_delivered("R2/R11");
        check("R7 one eof", neof, 1);
        check("R7 good status", est[0], 4'b0000);
    endtask

    task automatic test_shared_flags();
        clear_mon();
        send_raw(8'h7E); send_raw(8'h7E); send_raw(8'h7E);
        pay[0] = 8'hA1; pay[1] = 8'hB2; plen = 2;
        send_payload_fcs(); send_raw(8'h7E);
        pay[0] = 8'hC3; pay[1] = 8'hD4; plen = 2;
        send_payload_fcs(); send_raw(8'h7E);
        settle();
        check("R3 eof count", neof, 2);
        check("R3 octet count", ncap, 8);
        check("R3 frame1 status", est[0], 4'b0000);
        check("R3 frame2 status", est[1], 4'b0000);
        check("R3 frame2 sof", csof[4], 1);
        check("R3 frame2 first", cap[4], 8'hC3);
    endtask

    task automatic test_idle();
        clear_mon();
        send_idle(8'h7E);
        settle();
        check("R4 idle flag alone", neof + ncap, 0);
        pay[0] = 8'h55; pay[1] = 8'h66; pay[2] = 8'h77; plen = 3;
        send_raw(pay[0]); send_idle(8'h7D); send_raw(pay[1]);
        send_idle(8'h7E); send_raw(pay[2]); send_idle(8'h41);
        send_fcs(1'b0); send_raw(8'h7E);
        settle();
        check_delivered("R4");
        check("R4 status", est[0], 4'b0000);
    endtask

    task automatic test_escape();
        clear_mon();
        pay[0] = 8'h7E; pay[1] = 8'h7D; pay[2] = 8'h03; pay[3] = 8'h5D; plen = 4;
        send_payload_fcs(); send_raw(8'h7E);
        settle();
        check_delivered("R5 escaped");
        check("R5 escaped status", est[0], 4'b0000);
        clear_mon();
        pay[0] = 8'h5D; pay[1] = 8'h44; plen = 2;
        send_raw(8'h7D); send_raw(8'h7D); send_raw(8'h44); send_fcs(1'b0); send_raw(8'h7E);
        settle();
        check("R5 double escape", cap[0], 8'h5D);
        check("R5 double escape crc", est[0], 4'b0000);
        clear_mon();
        pay[0] = 8'h21; pay[1] = 8'h45; plen = 2;
        send_raw(8'h7D); send_raw(8'h01); send_raw(8'h45); send_fcs(1'b0); send_raw(8'h7E);
        settle();
        check("R5 unmapped ctrl escape", cap[0], 8'h21);
        check("R5 unmapped ctrl crc", est[0], 4'b0000);
    endtask

    task automatic test_map();
        clear_mon();
        rx_map = (32'h1 << 17) | (32'h1 << 19);
        pay[0] = 8'h41; pay[1] = 8'h42; pay[2] = 8'h7E; pay[3] = 8'h05; plen = 4;
        send_raw(8'h41); send_raw(8'h11); send_raw(8'h42); send_raw(8'h13);
        send_raw(8'h7D); send_raw(8'h11); send_raw(8'h5E); send_raw(8'h05);
        send_fcs(1'b0); send_raw(8'h7E);
        settle();
        check_delivered("R6");
        check("R6 status", est[0], 4'b0000);
        rx_map = 32'h0;
    endtask

    task automatic test_crc_err();
        clear_mon();
        pay[0] = 8'h12; pay[1] = 8'h34; pay[2] = 8'h56; pay[3] = 8'h78; plen = 4;
        for (int i = 0; i < plen; i++) send_enc(pay[i]);
        send_fcs(1'b1); send_raw(8'h7E);
        settle();
        check("R7 crc error", est[0], 4'b1000);
    endtask

    task automatic test_short();
        clear_mon();
        send_raw(8'hAA); send_raw(8'hBB); send_raw(8'hCC); send_raw(8'h7E);
        settle();
        check("R8 three octets short", est[0][2], 1);
        clear_mon();
        pay[0] = 8'h9A; pay[1] = 8'hBC; plen = 2;
        send_payload_fcs(); send_raw(8'h7E);
        settle();
        check("R8 four octets not short", est[0], 4'b0000);
    endtask

    task automatic test_abort();
        clear_mon();
        send_raw(8'h01 ^ 8'h00); send_raw(8'h7D);
        send_raw(8'h7E);
        settle();
        check("R9 abort eof", neof, 1);
        check("R9 abort status", est[0], 4'b0010);
        clear_mon();
        send_raw(8'h33); send_raw(8'h44);
        settle();
        check("R9 hunting after abort", ncap, 0);
        pay[0] = 8'h66; pay[1] = 8'h77; plen = 2;
        send_raw(8'h7E); send_payload_fcs(); send_raw(8'h7E);
        settle();
        check_delivered("R9 resync");
        check("R9 resync status", est[0], 4'b0000);
    endtask

    task automatic test_line_err();
        for (int k = 0; k < 4; k++) begin
            clear_mon();
            send_raw(8'h51); send_raw(8'h52);
            pulse_err(k);
            send_raw(8'h53);
            settle();
            check("R10 line eof", neof, 1);
            check("R10 line status", est[0], 4'b0001);
            check("R10 octets before error", ncap, 2);
            send_raw(8'h7E);
            clear_mon();
            pulse_err(k);
            settle();
            check("R10 error between frames", neof, 0);
            send_raw(8'h7E);
        end
        clear_mon();
        send_raw(8'h7D);
        pulse_err(0);
        settle();
        check("R10 escape pending eof", neof, 1);
        check("R10 escape pending status", est[0], 4'b0001);
        send_raw(8'h7E);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++; nchk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_good_frame();
        test_shared_flags();
        test_idle();
        test_escape();
        test_map();
        test_crc_err();
        test_short();
        test_abort();
        test_line_err();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule